// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim Tracking

This block gathers interrupt requests from a vector of level sources and presents one interrupt line to a single processor context. Every source except the reserved ID 0 has a latched pending bit, a 3-bit priority, an enable bit and a claimed bit. Combinational selection logic picks the best eligible source. The interrupt line is high while any source is eligible.

Software works through a small register bus with byte addresses, separate read and write strobes, and combinational read data. Reading the claim/complete register returns the ID of the selected source and marks that source as in service. Writing the same ID back to that register ends the service. While a source is in service, its input cannot raise its pending bit again, so a level that stays high does not produce a second claim of the same source.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending, claimed, enable, priority and threshold state is zero, `irq_o` is low, and a claim read returns 0.
- R2: The priority of source k (k >= 1) is at byte address 4*(k-1) starting at 0x000. A write keeps only data bits [2:0], and a read returns those three bits in the low bits. An address in that window that maps to a source ID of NUM_SRC or above ignores writes and reads 0.
- R3: Pending words are at 0x100, claimed words at 0x140 and enable words at 0x180, each holding 32 bits. Source n sits at bit n mod 32 of word n/32, which is at byte offset 4*(n/32) from the base. Source 0 is never pending, and its enable bit always reads 0.
- R4: A high source input sets the source's pending bit at the next clock edge. The bit stays set after the input falls and clears only when the source is claimed.
- R5: A source is eligible when it is pending and enabled and its priority is strictly greater than the threshold. The threshold is at 0x200, data bits [2:0].
- R6: Among eligible sources, the one with the highest priority is selected. When priorities are equal, the lowest ID wins.
- R7: `irq_o` is high exactly when an eligible source exists. It follows register state, so after the clock edge that changes that state it is valid in the same cycle.
- R8: A read of the claim/complete register at 0x204 returns the selected ID, or 0 when there is none. At the clock edge of that read, the selected source's pending bit clears and its claimed bit sets. A read that returns 0 changes nothing.
- R9: While a source's claimed bit is set, a high input on that source leaves its pending bit clear.
- R10: Writing an ID in the range 1 to NUM_SRC-1 to 0x204 clears that source's claimed bit. A write of 0 or of an ID out of range has no effect. Once the claimed bit is clear, an input that is still high sets the pending bit at the next edge.
- R11: Writes to a priority, an enable word or the threshold are reflected in `irq_o` and in the selected ID in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level interrupt inputs; bit 0 unused |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wr_i | input | 1 | Write strobe; if both strobes are high, the write takes effect and the read has no side effect |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | Interrupt request to the context |

## Verification
The bench targets ties in priority between sources in different pending words. A design that resolved ties wrongly would claim ID 33 before 7. It checks a priority exactly equal to the threshold, where a non-strict comparison would raise the line. It holds a claimed source's input high and reads the pending word. A design without claim gating would show the bit set again before completion. The bench also sends completions with IDs 0 and 50 and writes the enable bit of source 0, and each must leave the state as it was.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int WORD_W      = 32;
  localparam int OFS_PRIO    = 'h000;
  localparam int OFS_PEND    = 'h100;
  localparam int OFS_CLMD    = 'h140;
  localparam int OFS_ENA     = 'h180;
  localparam int OFS_THRESH  = 'h200;
  localparam int OFS_CLAIM   = 'h204;

  // word that holds a source's bit
  function automatic int word_of(input int n);
    return n / WORD_W;
  endfunction

  // bit position of a source inside its word
  function automatic int bit_of(input int n);
    return n % WORD_W;
  endfunction

  // byte address of the priority register for source k (k >= 1)
  function automatic int prio_addr(input int k);
    return OFS_PRIO + 4 * (k - 1);
  endfunction

endpackage

// File: rtl/prio_irq_cell.sv
module prio_irq_cell #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_i,
  input  logic              take_i,
  input  logic              done_i,
  input  logic              prio_we_i,
  input  logic [PRIO_W-1:0] prio_wdata_i,
  output logic              pend_o,
  output logic              clmd_o,
  output logic [PRIO_W-1:0] prio_o
);

  logic              pend_q, clmd_q;
  logic [PRIO_W-1:0] prio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      clmd_q <= 1'b0;
      prio_q <= '0;
    end else begin
      if (take_i)      pend_q <= 1'b0;
      else             pend_q <= pend_q | (src_i & ~clmd_q);
      if (take_i)      clmd_q <= 1'b1;
      else if (done_i) clmd_q <= 1'b0;
      if (prio_we_i)   prio_q <= prio_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign clmd_o = clmd_q;
  assign prio_o = prio_q;

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        elig_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thresh_i,
  output logic [ID_W-1:0]           id_o,
  output logic                      valid_o
);

  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;

  // strict compare keeps the earliest (lowest) ID on a tie
  always_comb begin
    best_p  = thresh_i;
    best_id = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (elig_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        best_p  = prio_i[i*PRIO_W +: PRIO_W];
        best_id = ID_W'(i);
      end
    end
  end

  assign id_o    = best_id;
  assign valid_o = (best_id != '0);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic               irq_o
);

  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int PAD       = NUM_WORDS * WORD_W;
  localparam logic [PAD-1:0] VALID_MASK =
    (((PAD+1)'(1) << NUM_SRC) - (PAD+1)'(1)) & ~(PAD+1)'(1);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_CLMD   = ADDR_W'(OFS_CLMD);
  localparam logic [ADDR_W-1:0] A_ENA    = ADDR_W'(OFS_ENA);
  localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFS_THRESH);
  localparam logic [ADDR_W-1:0] A_CLAIM  = ADDR_W'(OFS_CLAIM);
  localparam logic [ADDR_W-1:0] N_WORDS  = ADDR_W'(NUM_WORDS);

  // ---------------- bus decode ----------------
  logic              rd_eff;
  logic [ADDR_W-1:0] prio_src, pend_word, clmd_word, ena_word;
  logic              prio_hit, pend_hit, clmd_hit, ena_hit, thresh_hit, claim_hit;
  logic              prio_we, ena_we, thresh_we;
  logic              claim_fire, done_fire;
  logic [ID_W-1:0]   done_id;

  assign rd_eff     = bus_rd_i & ~bus_wr_i;
  assign prio_src   = (bus_addr_i >> 2) + ADDR_W'(1);
  assign prio_hit   = (bus_addr_i < A_PEND) && (prio_src < ADDR_W'(NUM_SRC));
  assign pend_word  = (bus_addr_i - A_PEND) >> 2;
  assign clmd_word  = (bus_addr_i - A_CLMD) >> 2;
  assign ena_word   = (bus_addr_i - A_ENA) >> 2;
  assign pend_hit   = (bus_addr_i >= A_PEND) && (pend_word < N_WORDS);
  assign clmd_hit   = (bus_addr_i >= A_CLMD) && (clmd_word < N_WORDS);
  assign ena_hit    = (bus_addr_i >= A_ENA)  && (ena_word  < N_WORDS);
  assign thresh_hit = (bus_addr_i == A_THRESH);
  assign claim_hit  = (bus_addr_i == A_CLAIM);

  assign prio_we    = bus_wr_i && prio_hit;
  assign ena_we     = bus_wr_i && ena_hit;
  assign thresh_we  = bus_wr_i && thresh_hit;
  assign claim_fire = rd_eff && claim_hit;
  assign done_fire  = bus_wr_i && claim_hit && (bus_wdata_i != '0) &&
                      (bus_wdata_i < WORD_W'(NUM_SRC));
  assign done_id    = bus_wdata_i[ID_W-1:0];

  // ---------------- per-source state ----------------
  logic [NUM_SRC-1:0]        pend_vec, clmd_vec;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [PAD-1:0]            pend_pad, clmd_pad, ena_q;
  logic [ID_W-1:0]           sel_id;
  logic                      sel_valid;
  logic [PRIO_W-1:0]         thresh_q;
  logic                      unused_src0;

  assign unused_src0 = src_i[0];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    if (n == 0) begin : g_rsv
      assign pend_vec[0]             = 1'b0;
      assign clmd_vec[0]             = 1'b0;
      assign prio_flat[PRIO_W-1:0]   = '0;
    end else begin : g_cell
      prio_irq_cell #(.PRIO_W(PRIO_W)) u_cell (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i[n]),
        .take_i       (claim_fire && (sel_id == ID_W'(n))),
        .done_i       (done_fire && (done_id == ID_W'(n))),
        .prio_we_i    (prio_we && (prio_src == ADDR_W'(n))),
        .prio_wdata_i (bus_wdata_i[PRIO_W-1:0]),
        .pend_o       (pend_vec[n]),
        .clmd_o       (clmd_vec[n]),
        .prio_o       (prio_flat[n*PRIO_W +: PRIO_W])
      );
    end
  end

  if (PAD > NUM_SRC) begin : g_pad
    assign pend_pad = {{(PAD-NUM_SRC){1'b0}}, pend_vec};
    assign clmd_pad = {{(PAD-NUM_SRC){1'b0}}, clmd_vec};
  end else begin : g_nopad
    assign pend_pad = pend_vec;
    assign clmd_pad = clmd_vec;
  end

  // ---------------- enable words and threshold ----------------
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ena
    always_ff @(posedge clk) begin
      if (!rst_n)
        ena_q[w*WORD_W +: WORD_W] <= '0;
      else if (ena_we && (ena_word == ADDR_W'(w)))
        ena_q[w*WORD_W +: WORD_W] <= bus_wdata_i & VALID_MASK[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         thresh_q <= '0;
    else if (thresh_we) thresh_q <= bus_wdata_i[PRIO_W-1:0];
  end

  // ---------------- selection ----------------
  prio_irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .elig_i   (pend_vec & ena_q[NUM_SRC-1:0]),
    .prio_i   (prio_flat),
    .thresh_i (thresh_q),
    .id_o     (sel_id),
    .valid_o  (sel_valid)
  );

  assign irq_o = sel_valid;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata_o = '0;
    if (prio_hit) begin
      for (int n = 1; n < NUM_SRC; n++)
        if (prio_src == ADDR_W'(n))
          bus_rdata_o[PRIO_W-1:0] = prio_flat[n*PRIO_W +: PRIO_W];
    end else if (pend_hit && (bus_addr_i < A_CLMD)) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (pend_word == ADDR_W'(w)) bus_rdata_o = pend_pad[w*WORD_W +: WORD_W];
    end else if (clmd_hit && (bus_addr_i < A_ENA)) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (clmd_word == ADDR_W'(w)) bus_rdata_o = clmd_pad[w*WORD_W +: WORD_W];
    end else if (ena_hit) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (ena_word == ADDR_W'(w)) bus_rdata_o = ena_q[w*WORD_W +: WORD_W];
    end else if (thresh_hit) begin
      bus_rdata_o[PRIO_W-1:0] = thresh_q;
    end else if (claim_hit) begin
      bus_rdata_o[ID_W-1:0] = sel_id;
    end
  end

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3,
  parameter int PAD     = 64,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      irq_o,
  input logic                      claim_fire,
  input logic                      done_fire,
  input logic [ID_W-1:0]           done_id,
  input logic [ID_W-1:0]           sel_id,
  input logic [PRIO_W-1:0]         thresh_q,
  input logic [PAD-1:0]            pend_pad,
  input logic [PAD-1:0]            clmd_pad,
  input logic [PAD-1:0]            ena_q,
  input logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input logic [31:0]               bus_rdata_o
);

  // selected source is pending, enabled and above threshold
  assert_sel_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_id != '0) |-> (pend_pad[sel_id] && ena_q[sel_id] &&
                        (prio_flat[sel_id*PRIO_W +: PRIO_W] > thresh_q)));

  // claim read moves the source from pending to claimed
  assert_claim_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && (sel_id != '0)) |=>
      (clmd_pad[$past(sel_id)] && !pend_pad[$past(sel_id)]));

  // claim read with no request returns zero
  assert_claim_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && !irq_o) |-> (bus_rdata_o == 32'd0));

  // no pending bit rises on a source that was claimed
  assert_claimed_no_repend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clmd_pad != '0) |=> ((pend_pad & ~$past(pend_pad) & $past(clmd_pad)) == '0));

  // completion clears the claimed bit
  assert_complete_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> !clmd_pad[$past(done_id)]);

  // reserved source 0 never pending or enabled
  assert_src0_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n |-> (!pend_pad[0] && !ena_q[0])));

endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .NUM_SRC (NUM_SRC),
  .PRIO_W  (PRIO_W),
  .PAD     (PAD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .claim_fire  (claim_fire),
  .done_fire   (done_fire),
  .done_id     (done_id),
  .sel_id      (sel_id),
  .thresh_q    (thresh_q),
  .pend_pad    (pend_pad),
  .clmd_pad    (clmd_pad),
  .ena_q       (ena_q),
  .prio_flat   (prio_flat),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

  localparam int NSRC = 40;
  localparam logic [11:0] A_PEND0 = 12'h100, A_PEND1 = 12'h104;
  localparam logic [11:0] A_CLM0  = 12'h140, A_CLM1  = 12'h144;
  localparam logic [11:0] A_ENA0  = 12'h180, A_ENA1  = 12'h184;
  localparam logic [11:0] A_THR   = 12'h200, A_CLAIM = 12'h204;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [11:0]     addr = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NSRC)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // byte address of source k's priority register
  function automatic logic [11:0] pa(input int k);
    return 12'(4 * (k - 1));
  endfunction

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (rd && !finished) begin
      vectors++;
      if (exp_q.size() == 0) begin
        misses++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          misses++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    vectors++;
    if (irq !== e) begin
      misses++;
      $display("FAIL %s: actual irq %b expected %b", t, irq, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    bus_read(A_CLAIM, 32'd0, "R1 claim after reset");
    bus_read(A_PEND0, 32'd0, "R1 pending after reset");
    bus_read(pa(5), 32'd0, "R1 priority after reset");

    // R2 priority layout and masking
    bus_write(pa(5), 32'hF);
    bus_read(pa(5), 32'd7, "R2 priority keeps low 3 bits");
    bus_write(pa(40), 32'h5);
    bus_read(pa(40), 32'd0, "R2 out-of-range priority ignored");

    // R4 latch of source 33 into word 1 bit 1 (R3)
    src[33] = 1'b1; idle(1); src[33] = 1'b0; idle(1);
    bus_read(A_PEND1, 32'h2, "R3 R4 source 33 pending after input drop");
    chk_irq(1'b0, "R5 not enabled, no request");

    // R5 strict threshold
    bus_write(A_ENA1, 32'h2);
    bus_write(pa(33), 32'd2);
    bus_write(A_THR, 32'd2);
    chk_irq(1'b0, "R5 priority equal to threshold");
    bus_write(A_THR, 32'd1);
    chk_irq(1'b1, "R11 threshold lowered raises irq");

    // R6 tie between 7 and 33
    src[7] = 1'b1; idle(1); src[7] = 1'b0;
    bus_write(pa(7), 32'd2);
    bus_write(A_ENA0, 32'h80);
    bus_read(A_CLAIM, 32'd7, "R6 tie goes to lowest ID");
    bus_read(A_CLM0, 32'h80, "R8 claimed bit set");
    bus_read(A_PEND0, 32'h0, "R8 pending bit cleared");
    bus_read(A_CLAIM, 32'd33, "R8 next claim");
    chk_irq(1'b0, "R7 nothing left");
    bus_read(A_CLAIM, 32'd0, "R8 claim with none");

    // R9 held input on claimed source
    src[7] = 1'b1; idle(3);
    bus_read(A_PEND0, 32'h0, "R9 claimed source stays unpended");
    bus_write(A_CLAIM, 32'd7);
    idle(1);
    bus_read(A_PEND0, 32'h80, "R10 re-pend after completion");
    src[7] = 1'b0;
    bus_read(A_CLM0, 32'h0, "R10 claimed bit cleared");
    chk_irq(1'b1, "R7 source 7 eligible again");

    // R10 ignored completions
    bus_write(A_CLAIM, 32'd0);
    bus_write(A_CLAIM, 32'd50);
    bus_read(A_CLM1, 32'h2, "R10 completion of 0 and 50 ignored");
    bus_write(A_CLAIM, 32'd33);
    bus_read(A_CLM1, 32'h0, "R10 completion of 33");

    // R3 enable of source 0, R6 highest priority
    bus_write(pa(20), 32'd5);
    bus_write(A_ENA0, 32'h0010_0081);
    bus_read(A_ENA0, 32'h0010_0080, "R3 source 0 enable reads zero");
    src[20] = 1'b1; idle(1); src[20] = 1'b0;
    bus_read(A_CLAIM, 32'd20, "R6 highest priority wins");
    bus_read(A_CLM0, 32'h0010_0000, "R8 claimed word after claim of 20");

    // R11 priority write re-evaluates
    chk_irq(1'b1, "R7 source 7 still eligible");
    bus_write(pa(7), 32'd1);
    chk_irq(1'b0, "R11 priority lowered to threshold drops irq");
    bus_write(A_THR, 32'd0);
    chk_irq(1'b1, "R11 threshold zero raises irq");
    bus_read(A_CLAIM, 32'd7, "R8 claim of 7");
    bus_read(A_CLM0, 32'h0010_0080, "R8 claimed word final");

    idle(2);
    if (exp_q.size() != 0) begin
      misses++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule